// File: doc/BRIEF.md
# Two-Pattern Test Phase Controller

This block sequences a built-in self-test pattern source made of a segmented binary counter and a segmented ones-complement accumulator. Each segment is k bits wide, and k is picked by a one-hot selection bus when a run starts. The controller watches the low k bits of both datapath registers and drives their control strobes through three arithmetic phases. By the end of a run, every k-bit accumulator group has stepped through every ordered pair of distinct k-bit values exactly once. These consecutive pairs are the two-pattern tests that a delay-fault or stuck-open test needs.

The datapath contract is as follows. The next counter value is `(cnt_rst ? 0 : cnt) + (cnt_hold ? 0 : 1)` in every group. The next accumulator value is all ones under `acc_set`, zero under `acc_clr`, and otherwise the old value plus the new counter value with end-around carry. All groups must move in step, because the all-ones test on the accumulator is by default a single AND over the whole bus. Cycle 0 of a run is the cycle after the initialisation step.

Top module: `twopat_phase_ctrl`

## Requirements
- R1: After a synchronous reset, and after a reset applied at any point in a run, `phase` is 0, `test_done` is 0 and `cnt_hold` is the only strobe that is high.
- R2: `start` is taken only in the idle or finished state. It is taken only when `pe_sel` has exactly one bit set at a position p of 1 or more, which selects k = p+1. Any other `pe_sel` value leaves the block idle, and no `acc_set` is issued.
- R3: In the cycle after an accepted start, `acc_set`, `cnt_rst` and `cnt_hold` are high, `acc_clr` is low and `phase` is 0. Cycle 0 therefore shows a counter of 0 and an accumulator of all ones.
- R4: In phase 1 (`phase`=1), the counter's low k bits equal 2^k-3 without the accumulator being all ones. The block then raises `cnt_rst` with `cnt_hold` low, so the counter runs 1..2^k-3 and restarts.
- R5: Phase 1 ends when the counter reads 2^k-3 and the accumulator reads all ones in the same cycle. The counter then advances, and `phase` reads 2 from the next cycle. For k=3 this first happens at cycle 36.
- R6: In phase 2, `cnt_hold` keeps the counter at 2^k-2 while the accumulator is not all ones. Once it is all ones, the block raises `cnt_rst` and `acc_clr` with `cnt_hold` low, and `phase` reads 3 from the next cycle. For k=3, phase 2 spans cycles 36 to 42.
- R7: In phase 3, `cnt_half` is high. Steps alternate between a hold-and-add step and an advance-and-clear step, so the (counter, accumulator) pairs run (c,0), (c,c) for c = 1 to 2^k-1.
- R8: `test_done` rises in the cycle where the counter reads 2^k-1 and the accumulator reads all ones during phase 3. That is cycle 2^k·(2^k-1), or cycle 56 for k=3.
- R9: Over cycles 0 to the end cycle, the accumulator shows every ordered pair of distinct k-bit values on consecutive cycles exactly once.
- R10: After the end, `test_done` stays high, `cnt_hold` stays high and `phase` reads 0 until reset or a new accepted start. A new start from there repeats the run with the same timing.
- R11: A `start` pulse during a run has no effect on the phase timing or on the end cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run |
| pe_sel | input | N | One-hot group-width select, bit p gives k=p+1 |
| cnt_val | input | N | Segmented counter output |
| acc_val | input | N | Segmented accumulator output |
| cnt_rst | output | 1 | Clear the counter before this cycle's increment |
| cnt_hold | output | 1 | Suppress the counter increment |
| cnt_half | output | 1 | Half-rate counting phase is active |
| acc_clr | output | 1 | Load zero into the accumulator |
| acc_set | output | 1 | Load all ones into the accumulator |
| test_done | output | 1 | End of the two-pattern test |
| phase | output | 2 | Current phase: 1, 2, 3, or 0 otherwise |

## Verification
The bench models a six-bit datapath arithmetically and runs complete tests for k=2 (three groups), k=3 (two groups) and k=6 (one group). The k=3 run pins the absolute phase boundaries and the end cycle. The other widths show that the end cycle follows 2^k·(2^k-1) and that pair coverage is complete and free of repeats for small and full-width groups. Invalid selections (none set, the k=1 bit, two bits) separate the acceptance rule from the decoder. A stray start during a run, a restart from the finished state and a mid-run reset separate state retention from state corruption.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_RUN1,
        ST_RUN2,
        ST_RUN3,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        logic cnt_rst;
        logic cnt_hold;
        logic cnt_half;
        logic acc_clr;
        logic acc_set;
        logic done;
    } ctl_cmd_t;

    localparam ctl_cmd_t CMD_NONE = '{cnt_rst: 1'b0, cnt_hold: 1'b0, cnt_half: 1'b0,
                                      acc_clr: 1'b0, acc_set: 1'b0, done: 1'b0};

    function automatic logic [1:0] phase_of(ctl_state_e s);
        case (s)
            ST_RUN1: return 2'd1;
            ST_RUN2: return 2'd2;
            ST_RUN3: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ptpc_width_decode.sv
module ptpc_width_decode #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] pe_sel,
    output logic         pe_ok,
    output logic [N-1:0] grp_mask
);
    logic [N-1:0] mask_d;

    // bit i of the mask is set when the selected position is i or above
    for (genvar i = 0; i < N; i++) begin : g_therm
        assign mask_d[i] = |(pe_sel >> i);
    end

    assign pe_ok = $onehot(pe_sel) && !pe_sel[0];

    always_ff @(posedge clk) begin
        if (rst)       grp_mask <= '0;
        else if (load) grp_mask <= mask_d;
    end

    AST_MASK_LOADED: assert property (@(posedge clk) disable iff (rst)
        load |=> (grp_mask[0] && grp_mask[1] && $countones(grp_mask) >= 2)); // R2

endmodule

// File: rtl/ptpc_match.sv
module ptpc_match #(
    parameter int N         = 16,
    parameter bit FULL_ONES = 1'b1
) (
    input  logic [N-1:0] grp_mask,
    input  logic [N-1:0] cnt_val,
    input  logic [N-1:0] acc_val,
    output logic         cnt_wrap,
    output logic         cnt_top,
    output logic         acc_full
);
    logic [N-1:0] cnt_low;
    logic [N-1:0] wrap_val;

    assign cnt_low  = cnt_val & grp_mask;
    assign wrap_val = grp_mask - N'(2);
    assign cnt_wrap = (cnt_low == wrap_val);
    assign cnt_top  = (cnt_low == grp_mask);

    if (FULL_ONES) begin : g_full_and
        assign acc_full = &acc_val;
    end else begin : g_masked
        assign acc_full = ((acc_val & grp_mask) == grp_mask);
    end

endmodule

// File: rtl/ptpc_seq.sv
module ptpc_seq
    import ptpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       pe_ok,
    input  logic       cnt_wrap,
    input  logic       cnt_top,
    input  logic       acc_full,
    output logic       load,
    output ctl_cmd_t   cmd,
    output logic [1:0] phase_o
);
    ctl_state_e state_q, state_d;
    logic       half_q, half_d;
    logic       accept;

    assign accept  = start && pe_ok;
    assign phase_o = phase_of(state_q);

    always_comb begin
        cmd     = CMD_NONE;
        state_d = state_q;
        half_d  = half_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd.cnt_hold = 1'b1;
                if (accept) begin
                    load    = 1'b1;
                    state_d = ST_INIT;
                end
            end
            ST_INIT: begin
                cmd.cnt_rst  = 1'b1;
                cmd.cnt_hold = 1'b1;
                cmd.acc_set  = 1'b1;
                state_d      = ST_RUN1;
            end
            ST_RUN1: begin
                if (cnt_wrap) begin
                    if (acc_full) state_d     = ST_RUN2;
                    else          cmd.cnt_rst = 1'b1;
                end
            end
            ST_RUN2: begin
                if (acc_full) begin
                    cmd.cnt_rst = 1'b1;
                    cmd.acc_clr = 1'b1;
                    half_d      = 1'b0;
                    state_d     = ST_RUN3;
                end else begin
                    cmd.cnt_hold = 1'b1;
                end
            end
            ST_RUN3: begin
                cmd.cnt_half = 1'b1;
                if (cnt_top && acc_full) begin
                    cmd.done     = 1'b1;
                    cmd.cnt_hold = 1'b1;
                    state_d      = ST_DONE;
                end else if (!half_q) begin
                    cmd.cnt_hold = 1'b1;
                    half_d       = 1'b1;
                end else begin
                    cmd.acc_clr = 1'b1;
                    half_d      = 1'b0;
                end
            end
            ST_DONE: begin
                cmd.cnt_hold = 1'b1;
                cmd.done     = 1'b1;
                if (accept) begin
                    load    = 1'b1;
                    state_d = ST_INIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cmd.done && !start) |=> cmd.done); // R10

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> (phase_o == 2'd0 || phase_o == 2'($past(phase_o) + 2'd1))); // R5

    AST_P3_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && $past(phase_o) == 2'd3 && !cmd.done) |-> (cmd.acc_clr != $past(cmd.acc_clr))); // R7

    AST_DONE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd.done) |-> (cnt_top && acc_full)); // R8

endmodule

// File: rtl/twopat_phase_ctrl.sv
module twopat_phase_ctrl
    import ptpc_pkg::*;
#(
    parameter int N         = 16,
    parameter bit FULL_ONES = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] pe_sel,
    input  logic [N-1:0] cnt_val,
    input  logic [N-1:0] acc_val,
    output logic         cnt_rst,
    output logic         cnt_hold,
    output logic         cnt_half,
    output logic         acc_clr,
    output logic         acc_set,
    output logic         test_done,
    output logic [1:0]   phase
);
    logic         pe_ok;
    logic         load;
    logic [N-1:0] grp_mask;
    logic         cnt_wrap;
    logic         cnt_top;
    logic         acc_full;
    ctl_cmd_t     cmd;

    ptpc_width_decode #(.N(N)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .pe_sel   (pe_sel),
        .pe_ok    (pe_ok),
        .grp_mask (grp_mask)
    );

    ptpc_match #(.N(N), .FULL_ONES(FULL_ONES)) u_match (
        .grp_mask (grp_mask),
        .cnt_val  (cnt_val),
        .acc_val  (acc_val),
        .cnt_wrap (cnt_wrap),
        .cnt_top  (cnt_top),
        .acc_full (acc_full)
    );

    ptpc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pe_ok    (pe_ok),
        .cnt_wrap (cnt_wrap),
        .cnt_top  (cnt_top),
        .acc_full (acc_full),
        .load     (load),
        .cmd      (cmd),
        .phase_o  (phase)
    );

    assign cnt_rst   = cmd.cnt_rst;
    assign cnt_hold  = cmd.cnt_hold;
    assign cnt_half  = cmd.cnt_half;
    assign acc_clr   = cmd.acc_clr;
    assign acc_set   = cmd.acc_set;
    assign test_done = cmd.done;

endmodule

// File: tb/twopat_phase_ctrl_tb.sv
`timescale 1ns/1ps
module twopat_phase_ctrl_tb;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB-1:0] pe_sel = '0;
    logic [NB-1:0] cnt_bus, acc_bus;
    logic          cnt_rst, cnt_hold, cnt_half, acc_clr, acc_set, test_done;
    logic [1:0]    phase;

    int kk = 2;
    int kmask;
    int m_c = 0, m_a = 0, c_nx, a_nx;
    int n_chk = 0, n_err = 0;
    bit seen [0:63][0:63];

    always #4 clk = ~clk;

    twopat_phase_ctrl #(.N(NB)) u_dut (
        .clk(clk), .rst(rst), .start(start), .pe_sel(pe_sel),
        .cnt_val(cnt_bus), .acc_val(acc_bus),
        .cnt_rst(cnt_rst), .cnt_hold(cnt_hold), .cnt_half(cnt_half),
        .acc_clr(acc_clr), .acc_set(acc_set), .test_done(test_done), .phase(phase)
    );

    function automatic int oc_add(int a, int b, int m);
        int s;
        s = a + b;
        if (s > m) s = (s & m) + 1;
        return s;
    endfunction

    // arithmetic model of one datapath group, replicated over the bus
    always_comb begin
        kmask = (1 << kk) - 1;
        c_nx  = ((cnt_rst ? 0 : m_c) + (cnt_hold ? 0 : 1)) & kmask;
        a_nx  = acc_set ? kmask : (acc_clr ? 0 : oc_add(m_a, c_nx, kmask));
        for (int i = 0; i < NB; i++) begin
            cnt_bus[i] = m_c[i % kk];
            acc_bus[i] = m_a[i % kk];
        end
    end

    always_ff @(posedge clk) begin
        m_c <= c_nx;
        m_a <= a_nx;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_k(input int k, input bit inject);
        int big_k, t, t2, t3, tdone, prev_a, prev_c, bad1, bad2, bad3, nhalf, dup, ntr, distinct;
        int p1c, p1a, p2a;
        big_k = 1 << k;
        t2 = -1; t3 = -1; tdone = -1; bad1 = 0; bad2 = 0; bad3 = 0; nhalf = 0;
        dup = 0; ntr = 0; p1c = -1; p1a = -1; p2a = -1;
        for (int u = 0; u < 64; u++) for (int v = 0; v < 64; v++) seen[u][v] = 1'b0;
        @(negedge clk);
        kk = k;
        pe_sel = NB'(1 << (k - 1));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(acc_set && cnt_rst && cnt_hold && !acc_clr && phase == 2'd0, "R3 init strobes",
            {acc_set, cnt_rst, cnt_hold, acc_clr}, 4'b1110);
        @(negedge clk);
        chk(m_c == 0 && m_a == big_k - 1, "R3 cycle0 values", m_a, big_k - 1);
        t = 0; prev_a = m_a; prev_c = m_c;
        while (t < 5000) begin
            if (t > 0) begin
                ntr++;
                if (seen[prev_a][m_a] || prev_a == m_a) dup++;
                seen[prev_a][m_a] = 1'b1;
            end
            if (phase == 2'd1 && t > 0 && (m_c < 1 || m_c > big_k - 3)) bad1++;
            if (phase == 2'd2 && t2 < 0) begin t2 = t; p1c = prev_c; p1a = prev_a; end
            if (phase == 2'd3 && t3 < 0) begin t3 = t; p2a = prev_a; end
            if (phase == 2'd2 && m_c != big_k - 2) bad2++;
            if (phase == 2'd3) begin
                if (!cnt_half) nhalf++;
                if (((t - t3) % 2) == 0) begin
                    if (m_a != 0 || m_c != (t - t3) / 2 + 1) bad3++;
                end else if (m_a != m_c) bad3++;
            end
            if (test_done) begin tdone = t; break; end
            prev_a = m_a; prev_c = m_c;
            start = inject && (t == 5);
            @(negedge clk);
            start = 1'b0;
            t++;
        end
        distinct = 0;
        for (int u = 0; u < big_k; u++) for (int v = 0; v < big_k; v++) if (seen[u][v]) distinct++;
        chk(bad1 == 0, "R4 phase1 counter range", bad1, 0);
        chk(p1c == big_k - 3 && p1a == big_k - 1, "R5 phase1 exit values", p1c, big_k - 3);
        chk(bad2 == 0 && p2a == big_k - 1, "R6 phase2 hold and exit", bad2, 0);
        chk(bad3 == 0 && nhalf == 0, "R7 phase3 pair order", bad3 + nhalf, 0);
        chk(tdone == big_k * (big_k - 1), "R8 end cycle", tdone, big_k * (big_k - 1));
        chk(m_c == big_k - 1 && m_a == big_k - 1, "R8 end values", m_a, big_k - 1);
        chk(dup == 0 && distinct == big_k * (big_k - 1) && ntr == distinct, "R9 pair coverage",
            distinct, big_k * (big_k - 1));
        if (k == 3) begin
            chk(t2 == 36, "R5 k3 phase2 entry", t2, 36);
            chk(t3 == 43, "R6 k3 phase3 entry", t3, 43);
            chk(tdone == 56, "R8 k3 end", tdone, 56);
            if (inject) chk(tdone == 56, "R11 stray start ignored", tdone, 56);
        end
    endtask

    task automatic hold_done(input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!test_done || !cnt_hold || phase != 2'd0 || acc_set) bad++;
        end
        chk(bad == 0, "R10 done held", bad, 0);
    endtask

    task automatic bad_start(input logic [NB-1:0] sel);
        int bad;
        bad = 0;
        @(negedge clk);
        pe_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (acc_set || phase != 2'd0 || test_done) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 invalid select ignored", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(phase == 2'd0 && !test_done && cnt_hold && !cnt_rst && !acc_set && !acc_clr && !cnt_half,
            "R1 reset state", {phase, test_done, cnt_hold}, 3'b001);
        bad_start(6'b000000);
        bad_start(6'b000001);
        bad_start(6'b000110);
        run_k(2, 1'b0);
        hold_done(20);
        run_k(2, 1'b0);   // R10 restart from finished state
        run_k(3, 1'b1);
        run_k(6, 1'b0);
        // R1 mid-run reset
        @(negedge clk);
        kk = 6; pe_sel = 6'b100000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(phase == 2'd0 && !test_done && cnt_hold && !acc_set && !acc_clr, "R1 mid-run reset",
            phase, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule